// File: doc/BRIEF.md
# Torque Reference Selector with Hold Timer

This block decides which current reference the winding sense comparators of a stepper driver compare against. It drives a two-bit select code that picks either the stepping-level reference or the lower holding-level reference. It also drives a flag that asks the analog side to scale the chosen reference down to 70.7%. Both phase pairs share the same select code and flag.

A timer whose length is set in clock cycles restarts on every step strobe. While it runs, the stepping level is selected. When it runs out, the holding level is selected until the next step, which saves power while the motor stands still. A length of zero turns holding off, and the stepping level is then used at all times.

In half-step operation with ripple compensation on, the block records on each step whether the position being entered energises one phase or two. It raises the scale flag for two-phase positions, so that alternating half-steps give equal torque. The flag and the drive position change on the same clock edge.

Top module: `trq_ref_sel`

## Requirements
- R1: After reset, with a non-zero timeout length, the select code is holding (2'b10).
- R2: On the cycle after a clock edge that samples `step_i` high, the select code is stepping (2'b01).
- R3: After a step, with timeout length N > 0, the stepping code lasts exactly N cycles. It then returns to holding until the next step.
- R4: A step that arrives while the timeout runs restarts the full N-cycle window from that step.
- R5: When `hold_len_i` is zero, the select code is stepping (2'b01) in every cycle, including right after reset.
- R6: With `comp_en_i` and `half_mode_i` both high, `scale_o` is 1 when the recorded position is two-phase-on and 0 when it is one-phase-on. The position is recorded from `one_on_i` only on a step edge and is visible on the next cycle. Changes of `one_on_i` between steps have no effect.
- R7: When `half_mode_i` is low (full step), `scale_o` is 0 whatever the other inputs are.
- R8: When `comp_en_i` is low, `scale_o` is 0.
- R9: After reset the recorded position is two-phase-on, the home position. With compensation and half-step on, `scale_o` is therefore 1 before any step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | Step strobe, one cycle per step, aligned with the position update |
| hold_len_i | input | CNT_W (16) | Stepping-torque timeout in cycles; 0 disables holding |
| one_on_i | input | 1 | 1 when the position entered on this step is one-phase-on |
| comp_en_i | input | 1 | Ripple compensation enable (tie high by default) |
| half_mode_i | input | 1 | 1 selects half-step, 0 full-step |
| ref_sel_o | output | 2 | 2'b01 stepping reference, 2'b10 holding reference |
| scale_o | output | 1 | 1 asks for the reference scaled to 70.7% |

## Verification
The select code moves to stepping one cycle after the edge that samples the strobe. It stays there for exactly N cycles and is back at holding on cycle N+1. The bench drives inputs on the falling edge and samples at the next falling edge, so it checks each of these cycles individually. The scale flag follows a step one cycle later, when the recorded position updates. Changes to the mode inputs show on the flag in the same cycle, since the flag is not registered. The bench checks both immediately after the input change that causes them.

// File: rtl/trq_pkg.sv
// Package: shared codes for the torque reference selector.
// Assumes the analog side decodes a one-hot two-bit select.
package trq_pkg;
    typedef enum logic [1:0] {
        REF_STEP = 2'b01,
        REF_HOLD = 2'b10
    } ref_code_t;
endpackage

// File: rtl/trq_hold_timer.sv
// Module: trq_hold_timer
// Retriggerable timeout. A step loads the length and raises 'running'.
// 'running' stays high for exactly 'len_i' cycles after the step edge.
// Assumes step_i is a single-cycle strobe; a length of zero never raises running.
module trq_hold_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             running_o
);
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Load on step, count down while running, drop after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
            run_q <= 1'b0;
        end else if (step_i) begin
            cnt_q <= len_i;
            run_q <= (len_i != ZERO);
        end else if (run_q) begin
            if (cnt_q <= ONE) begin
                cnt_q <= ZERO;
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign running_o = run_q;
endmodule

// File: rtl/trq_phase_track.sv
// Module: trq_phase_track
// Records, on each step, whether the entered position is one-phase-on.
// Derives the 70.7% scale request from it.
// Assumes one_on_i is valid in the step cycle and describes the position
// the translator loads on the same edge. Reset gives the home state (two-on).
module trq_phase_track (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic one_on_i,
    input  logic comp_en_i,
    input  logic half_mode_i,
    output logic scale_o
);
    logic one_on_q;

    // Capture the phase count of the position entered at each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            one_on_q <= 1'b0;
        end else if (step_i) begin
            one_on_q <= one_on_i;
        end
    end

    // Scale only two-phase-on positions, only in compensated half-step.
    always_comb begin
        scale_o = comp_en_i & half_mode_i & ~one_on_q;
    end
endmodule

// File: rtl/trq_ref_sel.sv
// Module: trq_ref_sel (top)
// Selects the stepping or holding current reference and the 70.7% scaling
// request for the sense comparators of both phase pairs.
// Assumes synchronous inputs and a one-cycle step strobe.
module trq_ref_sel
    import trq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [CNT_W-1:0] hold_len_i,
    input  logic             one_on_i,
    input  logic             comp_en_i,
    input  logic             half_mode_i,
    output logic [1:0]       ref_sel_o,
    output logic             scale_o
);
    localparam logic [CNT_W-1:0] LEN_OFF = '0;

    logic      running;
    ref_code_t code;

    trq_hold_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_i),
        .len_i     (hold_len_i),
        .running_o (running)
    );

    trq_phase_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step_i),
        .one_on_i    (one_on_i),
        .comp_en_i   (comp_en_i),
        .half_mode_i (half_mode_i),
        .scale_o     (scale_o)
    );

    // Stepping level while the timer runs or when holding is disabled.
    always_comb begin
        if (hold_len_i == LEN_OFF || running) begin
            code = REF_STEP;
        end else begin
            code = REF_HOLD;
        end
    end

    assign ref_sel_o = code;
endmodule

// File: rtl/trq_ref_sel_chk.sv
// Module: trq_ref_sel_chk
// Temporal checks on the selector's ports, attached to every instance by bind.
module trq_ref_sel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_i,
    input logic [CNT_W-1:0] hold_len_i,
    input logic             one_on_i,
    input logic             comp_en_i,
    input logic             half_mode_i,
    input logic [1:0]       ref_sel_o,
    input logic             scale_o
);
    // R2: a step with holding enabled gives the stepping code next cycle.
    a_r2_step_selects: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && hold_len_i != '0 && $stable(hold_len_i)) |=> ref_sel_o == 2'b01);

    // R3: holding is only entered when no step was sampled on the edge before.
    a_r3_hold_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_sel_o[1]) |-> !$past(step_i));

    // R5: a zero length always selects stepping.
    a_r5_disabled_steps: assert property (@(posedge clk) disable iff (!rst_n)
        hold_len_i == '0 |-> ref_sel_o == 2'b01);

    // R6: after a step in compensated half-step, the flag marks two-phase-on.
    a_r6_scale_follows: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (!(comp_en_i && half_mode_i) || scale_o == !$past(one_on_i)));

    // R7: full-step never scales.
    a_r7_full_no_scale: assert property (@(posedge clk) disable iff (!rst_n)
        !half_mode_i |-> !scale_o);

    // R8: compensation off never scales.
    a_r8_comp_off: assert property (@(posedge clk) disable iff (!rst_n)
        !comp_en_i |-> !scale_o);

    // R1: the select code is always exactly one of the two legal codes.
    a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ref_sel_o) == 1);
endmodule

bind trq_ref_sel trq_ref_sel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_i),
    .hold_len_i  (hold_len_i),
    .one_on_i    (one_on_i),
    .comp_en_i   (comp_en_i),
    .half_mode_i (half_mode_i),
    .ref_sel_o   (ref_sel_o),
    .scale_o     (scale_o)
);

// File: tb/sim_trq_ref_sel.sv
// Directed bench: inputs change on the falling edge, outputs sampled on it.
module sim_trq_ref_sel;
    localparam int CNT_W = 16;
    localparam logic [1:0] STEP = 2'b01;
    localparam logic [1:0] HOLD = 2'b10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             step_i = 1'b0;
    logic [CNT_W-1:0] hold_len_i = 16'd5;
    logic             one_on_i = 1'b0;
    logic             comp_en_i = 1'b1;
    logic             half_mode_i = 1'b1;
    logic [1:0]       ref_sel_o;
    logic             scale_o;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    trq_ref_sel #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .hold_len_i(hold_len_i),
        .one_on_i(one_on_i), .comp_en_i(comp_en_i), .half_mode_i(half_mode_i),
        .ref_sel_o(ref_sel_o), .scale_o(scale_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step_i = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    // One strobe; returns at the first falling edge after the sampling edge.
    task automatic pulse(input logic one_on);
        step_i = 1'b1;
        one_on_i = one_on;
        cyc(1);
        step_i = 1'b0;
    endtask

    task automatic t_reset();
        hold_len_i = 16'd5; comp_en_i = 1'b1; half_mode_i = 1'b1;
        do_reset();
        check(ref_sel_o == HOLD, "R1 reset code", ref_sel_o, HOLD);
        check(scale_o == 1'b1, "R9 home two-on scale", scale_o, 1);
    endtask

    task automatic t_window();
        hold_len_i = 16'd5;
        pulse(1'b1);
        check(ref_sel_o == STEP, "R2 step code", ref_sel_o, STEP);
        for (int i = 2; i <= 5; i++) begin
            cyc(1);
            check(ref_sel_o == STEP, "R3 window", ref_sel_o, STEP);
        end
        cyc(1);
        check(ref_sel_o == HOLD, "R3 expiry", ref_sel_o, HOLD);
        cyc(10);
        check(ref_sel_o == HOLD, "R3 stays hold", ref_sel_o, HOLD);
    endtask

    task automatic t_retrigger();
        hold_len_i = 16'd5;
        pulse(1'b0);
        cyc(3);
        pulse(1'b1);
        for (int i = 1; i <= 5; i++) begin
            check(ref_sel_o == STEP, "R4 restarted window", ref_sel_o, STEP);
            cyc(1);
        end
        check(ref_sel_o == HOLD, "R4 expiry after restart", ref_sel_o, HOLD);
    endtask

    task automatic t_len_one();
        hold_len_i = 16'd1;
        pulse(1'b1);
        check(ref_sel_o == STEP, "R3 len1 step", ref_sel_o, STEP);
        cyc(1);
        check(ref_sel_o == HOLD, "R3 len1 hold", ref_sel_o, HOLD);
    endtask

    task automatic t_disabled();
        hold_len_i = 16'd0;
        do_reset();
        check(ref_sel_o == STEP, "R5 reset disabled", ref_sel_o, STEP);
        pulse(1'b0);
        cyc(20);
        check(ref_sel_o == STEP, "R5 idle disabled", ref_sel_o, STEP);
        hold_len_i = 16'd4;
        cyc(1);
        check(ref_sel_o == HOLD, "R1 enable after idle", ref_sel_o, HOLD);
    endtask

    task automatic t_scale();
        comp_en_i = 1'b1; half_mode_i = 1'b1;
        pulse(1'b1);
        check(scale_o == 1'b0, "R6 one-on no scale", scale_o, 0);
        one_on_i = 1'b0;
        cyc(2);
        check(scale_o == 1'b0, "R6 ignore between steps", scale_o, 0);
        pulse(1'b0);
        check(scale_o == 1'b1, "R6 two-on scaled", scale_o, 1);
    endtask

    task automatic t_modes();
        half_mode_i = 1'b0;
        #1;
        check(scale_o == 1'b0, "R7 full step", scale_o, 0);
        pulse(1'b0);
        check(scale_o == 1'b0, "R7 full after step", scale_o, 0);
        half_mode_i = 1'b1;
        #1;
        check(scale_o == 1'b1, "R6 half restored", scale_o, 1);
        comp_en_i = 1'b0;
        #1;
        check(scale_o == 1'b0, "R8 comp off", scale_o, 0);
        comp_en_i = 1'b1;
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_window();
        t_retrigger();
        t_len_one();
        t_scale();
        t_modes();
        t_disabled();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule